// File: doc/BRIEF.md
# Streaming Echo Verification Checker

This block confirms that a set of vote choices sent to a remote host came back unchanged. During confirmation the host echoes the choice bytes back one at a time. Each echoed byte is compared as it arrives against the byte held at the matching address of a small local choice memory. Nothing is buffered. A single pass/fail flag is raised once the last byte has been compared.

A controller pulses `start` to open a check. The block then drives the memory read address from a counter that moves forward by one on every accepted echo byte. The memory answers combinationally on `ref_byte`. A mismatch at any position latches an internal error bit. After the fourth accepted byte, `done` pulses for one cycle and `tx_good` shows the verdict. `tx_good` keeps that value until the next `start`.

Top module: `echo_verify`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rd_addr` is 0, `done` is 0 and `tx_good` is 0.
- R2: In the cycle after `start` is high, `rd_addr` is 0, `done` is 0 and `tx_good` is 0, whatever the previous result was.
- R3: During a check, each cycle with `echo_vld` high and `start` low accepts one byte and moves `rd_addr` forward by one, modulo 4. The address wraps to 0 after the fourth byte. In cycles with `echo_vld` low, `rd_addr` holds.
- R4: When all four accepted bytes equal `ref_byte` at their addresses 0, 1, 2, 3, `tx_good` is 1 in the cycle after the fourth byte is accepted.
- R5: A mismatch on any single byte position makes `tx_good` 0 at the end of that check.
- R6: `done` is high for exactly one cycle: the cycle after the fourth byte is accepted. `tx_good` takes its verdict in that same cycle.
- R7: After a check completes, further valid echo bytes are ignored. `rd_addr` and `tx_good` stay unchanged and `done` stays low.
- R8: After reset and before any `start`, valid echo bytes are ignored. `rd_addr` stays 0 and `done` and `tx_good` stay 0.
- R9: When `start` and `echo_vld` are high in the same cycle, the restart wins and that byte is not counted. A new check of four bytes follows.
- R10: `tx_good` keeps its verdict until the next `start` or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a new check; clears the address and the previous result |
| echo_vld | input | 1 | An echoed byte is present this cycle |
| echo_byte | input | 8 | Echoed byte from the host |
| ref_byte | input | 8 | Choice memory data at `rd_addr` (combinational read) |
| rd_addr | output | 2 | Choice memory read address |
| done | output | 1 | One-cycle pulse after the fourth byte |
| tx_good | output | 1 | 1 when every byte of the last check matched |

## Verification
Three results are checked, and each is due at a fixed number of register stages after its stimulus:
- `rd_addr` moves one cycle after an accepted byte.
- `done` and `tx_good` change one cycle after the fourth byte is accepted.
- `done` falls one cycle after that.

The bench drives inputs on the falling edge and samples on the next falling edge. Each sample therefore lands exactly one rising edge after the stimulus it checks. Idle gaps of random length between bytes confirm that these latencies depend on accepted bytes, not on elapsed cycles.

// File: rtl/echo_chk_pkg.sv
package echo_chk_pkg;

    parameter int BYTE_W    = 8;
    parameter int NUM_BYTES = 4;
    localparam int IDX_W    = $clog2(NUM_BYTES);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_END  = 2'd2
    } phase_e;

    // One accepted echo beat as seen by the verdict logic
    typedef struct packed {
        logic take;
        logic last;
        logic differ;
    } beat_t;

    function automatic logic is_last(idx_t i);
        return i == idx_t'(NUM_BYTES - 1);
    endfunction

endpackage

// File: rtl/echo_seq.sv
module echo_seq
    import echo_chk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   echo_vld,
    output phase_e phase,
    output idx_t   idx,
    output logic   take,
    output logic   last
);

    assign take = (phase == PH_RUN) && echo_vld && !start;
    assign last = is_last(idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            idx   <= '0;
        end else if (start) begin
            phase <= PH_RUN;
            idx   <= '0;
        end else if (take) begin
            idx <= idx + 1'b1;
            if (last) begin
                phase <= PH_END;
            end
        end
    end

endmodule

// File: rtl/echo_cmp.sv
module echo_cmp
    import echo_chk_pkg::*;
(
    input  byte_t got,
    input  byte_t want,
    output logic  differ
);

    logic [BYTE_W-1:0] lane_diff;

    for (genvar b = 0; b < BYTE_W; b++) begin : g_lane
        assign lane_diff[b] = got[b] ^ want[b];
    end

    assign differ = |lane_diff;

endmodule

// File: rtl/echo_verdict.sv
module echo_verdict
    import echo_chk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  beat_t beat,
    output logic  done,
    output logic  good
);

    logic err_q;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            err_q <= 1'b0;
            done  <= 1'b0;
            good  <= 1'b0;
        end else begin
            done <= beat.take && beat.last;
            if (beat.take && beat.differ) begin
                err_q <= 1'b1;
            end
            if (beat.take && beat.last) begin
                good <= !(err_q || beat.differ);
            end
        end
    end

endmodule

// File: rtl/echo_verify.sv
module echo_verify
    import echo_chk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             echo_vld,
    input  logic [BYTE_W-1:0] echo_byte,
    input  logic [BYTE_W-1:0] ref_byte,
    output logic [IDX_W-1:0]  rd_addr,
    output logic             done,
    output logic             tx_good
);

    phase_e phase;
    idx_t   idx;
    logic   take;
    logic   last;
    logic   differ;
    beat_t  beat;

    echo_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .echo_vld (echo_vld),
        .phase    (phase),
        .idx      (idx),
        .take     (take),
        .last     (last)
    );

    echo_cmp u_cmp (
        .got    (echo_byte),
        .want   (ref_byte),
        .differ (differ)
    );

    assign beat = '{take: take, last: last, differ: differ};

    echo_verdict u_verdict (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .beat  (beat),
        .done  (done),
        .good  (tx_good)
    );

    assign rd_addr = idx;

endmodule

// File: rtl/echo_verify_sva.sv
module echo_verify_sva
    import echo_chk_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   start,
    input logic   echo_vld,
    input byte_t  echo_byte,
    input byte_t  ref_byte,
    input idx_t   rd_addr,
    input logic   done,
    input logic   tx_good,
    input phase_e phase
);

    logic accept;
    assign accept = (phase == PH_RUN) && echo_vld && !start;

    // R2
    restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (rd_addr == '0) && !done && !tx_good);

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> rd_addr == idx_t'($past(rd_addr) + 1'b1));

    // R4
    good_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_good) |-> done);

    // R5
    mismatch_fail_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && (echo_byte != ref_byte)) |=> !tx_good);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    idle_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_RUN && !start) |=> $stable(rd_addr) && $stable(tx_good) && !done);

endmodule

bind echo_verify echo_verify_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .echo_vld  (echo_vld),
    .echo_byte (echo_byte),
    .ref_byte  (ref_byte),
    .rd_addr   (rd_addr),
    .done      (done),
    .tx_good   (tx_good),
    .phase     (phase)
);

// File: tb/tb_echo_verify.sv
module tb_echo_verify;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic       echo_vld;
    logic [7:0] echo_byte;
    logic [7:0] ref_byte;
    logic [1:0] rd_addr;
    logic       done;
    logic       tx_good;

    logic [7:0] mem [4];
    logic [7:0] echo_q [4];

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    assign ref_byte = mem[rd_addr];

    echo_verify dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .echo_vld  (echo_vld),
        .echo_byte (echo_byte),
        .ref_byte  (ref_byte),
        .rd_addr   (rd_addr),
        .done      (done),
        .tx_good   (tx_good)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_good();
        for (int i = 0; i < 4; i++) begin
            if (echo_q[i] != mem[i]) return 0;
        end
        return 1;
    endfunction

    task automatic do_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 addr", int'(rd_addr), 0);
        chk("R2 done", int'(done), 0);
        chk("R2 good", int'(tx_good), 0);
    endtask

    task automatic feed_all(input int gap_max);
        int g;
        for (int i = 0; i < 4; i++) begin
            g = (gap_max == 0) ? 0 : int'($urandom % (gap_max + 1));
            repeat (g) @(negedge clk);
            chk("R3 addr", int'(rd_addr), i);
            echo_vld  = 1'b1;
            echo_byte = echo_q[i];
            @(negedge clk);
            echo_vld = 1'b0;
            if (i < 3) chk("R6 early done", int'(done), 0);
        end
        chk("R6 done", int'(done), 1);
        chk("R4/R5 good", int'(tx_good), exp_good());
        @(negedge clk);
        chk("R6 pulse end", int'(done), 0);
        chk("R10 good hold", int'(tx_good), exp_good());
    endtask

    task automatic fill_random();
        for (int i = 0; i < 4; i++) begin
            mem[i]    = 8'($urandom);
            echo_q[i] = mem[i];
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        int keep;
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; start = 1'b0; echo_vld = 1'b0; echo_byte = '0;
        fill_random();
        repeat (3) @(negedge clk);
        chk("R1 addr", int'(rd_addr), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 good", int'(tx_good), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", int'(tx_good), 0);

        // R8: bytes before any start are ignored
        echo_vld = 1'b1; echo_byte = mem[0];
        repeat (3) @(negedge clk);
        echo_vld = 1'b0;
        chk("R8 addr", int'(rd_addr), 0);
        chk("R8 done", int'(done), 0);
        chk("R8 good", int'(tx_good), 0);

        // R4: all bytes match, back to back
        do_start();
        feed_all(0);

        // R10: verdict holds over idle cycles
        repeat (6) @(negedge clk);
        chk("R10 good held", int'(tx_good), 1);

        // R7: bytes after done are ignored
        echo_vld = 1'b1; echo_byte = ~mem[0];
        repeat (3) @(negedge clk);
        chk("R7 done", int'(done), 0);
        echo_vld = 1'b0;
        chk("R7 addr", int'(rd_addr), 0);
        chk("R7 good", int'(tx_good), 1);

        // R5: one mismatch at each position
        for (int p = 0; p < 4; p++) begin
            fill_random();
            echo_q[p] = echo_q[p] ^ (8'd1 << p);
            do_start();
            feed_all(1);
            chk("R5 position fail", int'(tx_good), 0);
        end

        // R9: start with valid in the same cycle restarts the check
        fill_random();
        do_start();
        echo_vld = 1'b1; echo_byte = mem[0];
        @(negedge clk);
        echo_byte = mem[1];
        @(negedge clk);
        chk("R9 mid addr", int'(rd_addr), 2);
        start = 1'b1; echo_byte = 8'hFF;
        @(negedge clk);
        start = 1'b0; echo_vld = 1'b0;
        chk("R9 restart addr", int'(rd_addr), 0);
        chk("R9 restart done", int'(done), 0);
        feed_all(2);

        // R2: start clears a good verdict
        chk("R2 prior good", int'(tx_good), 1);
        do_start();

        // Random runs
        for (int r = 0; r < 40; r++) begin
            fill_random();
            if ($urandom % 2 == 1) begin
                keep = int'($urandom % 4);
                echo_q[keep] = echo_q[keep] ^ 8'(1 + ($urandom % 255));
            end
            if (r != 0) do_start();
            feed_all(3);
        end

        summary();
        $finish;
    end

endmodule